// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block runs on the memory-controller side. It takes a DDR2 SDRAM from the moment supply and clock are stable to the point where normal traffic may begin. After a `start` pulse it checks the requested CAS latency, additive latency and burst length. If any of them is illegal, it raises a configuration error and stays idle.

For a legal configuration it keeps clock-enable low for a programmable settling time. It then drives NOP with clock-enable high and issues the mandated eleven-command sequence on the command/address pins. Each command is spaced by a programmable cycle count that depends on the kind of command issued.

Two flags tell the rest of the controller when it may proceed. `init_done` goes high once the sequence and its final spacing are complete. `rd_allowed` goes high once the delay-locked loop has had its lock interval after being reset. All wait intervals are parameters given in clock cycles, so a fast simulation can shorten them.

Top module: `ddr2_init_seq`

## Requirements
- R1: After synchronous reset `cke` is 0, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and `init_done`, `rd_allowed` and `cfg_err` are 0. The block stays there until `start` is seen.
- R2: On a `start` with legal settings, `cke` stays 0 for `T_PWR` cycles counted from the start edge and then rises. NOP is then driven for `T_NOP` cycles before the first command.
- R3: The commands appear in this order: precharge-all, load BA=2, load BA=3, load BA=1 (extended, DLL on), load BA=0 (DLL reset), precharge-all, refresh, refresh, load BA=0 (no DLL reset), load BA=1 (calibration default), load BA=1 (calibration exit). No other command is issued. Encodings are precharge 0010 with A10=1, refresh 0001 and load 0000, all with address and bank zero except where stated.
- R4: The distance from one command to the next is exactly `T_RPA` cycles after a precharge, `T_RFC` after a refresh and `T_MRD` after a load. NOP fills the cycles in between.
- R5: Extended loads use BA=1 with A0=0 (DLL enabled), A1 = `drive_reduced`, A5:3 = additive latency, and A9:7 = 111 for the calibration-default load or 000 otherwise. All other bits are 0. The BA=2 and BA=3 loads carry an all-zero address.
- R6: Base loads use BA=0 with A2:0 = 010 for burst 4 or 011 for burst 8, A6:4 = CAS latency, A8 = 1 only in the first base load, and A11:9 = `T_WR`-1. All other bits are 0.
- R7: `init_done` rises exactly `T_MRD` cycles after the calibration-exit load. It then stays high with NOP on the pins.
- R8: `rd_allowed` rises exactly `T_DLL` cycles after the DLL-reset load, or together with `init_done` if that comes later. It is never high before `init_done`.
- R9: A `start` with CAS latency outside 3..7, additive latency above 5, or burst length other than 4 or 8 sets `cfg_err` on the next cycle, keeps `cke` low and issues no command. A later legal `start` clears `cfg_err` and runs the sequence.
- R10: Settings are captured at the accepted `start`. Later changes to the setting inputs, and further `start` pulses, have no effect on the commands issued.
- R11: A synchronous reset during the sequence returns `cke` to 0 and clears all flags, and no command follows until a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin initialization (taken only while idle) |
| cas_lat | input | 3 | Requested CAS latency |
| add_lat | input | 3 | Requested additive latency |
| burst_len | input | 4 | Requested burst length (4 or 8) |
| drive_reduced | input | 1 | 1 selects reduced output drive |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | A_W | Address / mode word |
| init_done | output | 1 | Sequence complete |
| rd_allowed | output | 1 | DLL lock interval elapsed, reads permitted |
| cfg_err | output | 1 | Last start carried illegal settings |

## Verification
All outputs are decoded from registered state, so each result shows on the pins one edge after the cycle that causes it. The bench counts edges from the edge that samples `start`. It predicts the clock-enable rise at `T_PWR` edges and the first command at `T_PWR`+`T_NOP`. Each later command is predicted at the running sum of the per-kind spacings. `init_done` is due `T_MRD` after the last load, and `rd_allowed` is due at the later of `T_DLL` after the DLL-reset load and `init_done`. The scoreboard stores each expected command with its absolute edge number. The monitor samples at the falling clock edge and requires the command, bank, address and edge number to match. The flag checks are made one cycle before and exactly at the predicted edge.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_PRE = 4'b0010,
      CMD_REF = 4'b0001,
      CMD_LMR = 4'b0000
   } dcmd_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWR,
      ST_NOPW,
      ST_CMD,
      ST_GAP,
      ST_DONE
   } ist_t;

   localparam int NUM_STEPS  = 11;
   localparam int STEP_DLLRST = 4;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr2_init_cfg.sv
module ddr2_init_cfg #(
   parameter int A_W  = 14,
   parameter int T_WR = 3
) (
   input  logic [2:0]     cas_lat,
   input  logic [2:0]     add_lat,
   input  logic [3:0]     burst_len,
   input  logic           drive_reduced,
   output logic           cfg_ok,
   output logic [A_W-1:0] mr_word,
   output logic [A_W-1:0] emr_word
);
   localparam logic [2:0] WR_CODE = 3'(T_WR - 1);

   if (T_WR < 2 || T_WR > 6) begin : g_bad_wr
      $error("ddr2_init_cfg: T_WR must lie in 2..6");
   end

   logic cl_ok, al_ok, bl_ok;

   always_comb begin
      cl_ok  = (cas_lat >= 3'd3);
      al_ok  = (add_lat <= 3'd5);
      bl_ok  = (burst_len == 4'd4) || (burst_len == 4'd8);
      cfg_ok = cl_ok && al_ok && bl_ok;

      mr_word       = '0;
      mr_word[2:0]  = (burst_len == 4'd8) ? 3'b011 : 3'b010;
      mr_word[6:4]  = cas_lat;
      mr_word[11:9] = WR_CODE;

      emr_word      = '0;
      emr_word[1]   = drive_reduced;
      emr_word[5:3] = add_lat;
   end

endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] val,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/ddr2_init_dll_gate.sv
module ddr2_init_dll_gate #(
   parameter int T_DLL = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   output logic locked
);
   localparam int DW = $clog2(T_DLL + 1);

   if (T_DLL < 1) begin : g_bad_dll
      $error("ddr2_init_dll_gate: T_DLL must be at least 1");
   end

   logic [DW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk) begin
      if (rst) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (arm) begin
         run <= 1'b1;
         cnt <= DW'(1);
      end else if (run && cnt != DW'(T_DLL)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign locked = run && (cnt == DW'(T_DLL));

   // R8: once the lock interval is met it stays met
   a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
      locked |=> locked);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
   import ddr2_init_pkg::*;
#(
   parameter int A_W   = 14,
   parameter int BA_W  = 3,
   parameter int T_PWR = 10000,
   parameter int T_NOP = 20,
   parameter int T_RPA = 2,
   parameter int T_MRD = 2,
   parameter int T_RFC = 7,
   parameter int T_DLL = 200,
   parameter int T_WR  = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [2:0]      cas_lat,
   input  logic [2:0]      add_lat,
   input  logic [3:0]      burst_len,
   input  logic            drive_reduced,
   output logic            cke,
   output logic            cs_n,
   output logic            ras_n,
   output logic            cas_n,
   output logic            we_n,
   output logic [BA_W-1:0] ba,
   output logic [A_W-1:0]  addr,
   output logic            init_done,
   output logic            rd_allowed,
   output logic            cfg_err
);
   localparam int MAXW = imax(imax(T_PWR, T_NOP), imax(imax(T_RPA, T_MRD), T_RFC));
   localparam int CW   = $clog2(MAXW + 1);
   localparam logic [3:0] LAST = 4'(NUM_STEPS - 1);

   if (A_W < 12) begin : g_bad_aw
      $error("ddr2_init_seq: A_W must be at least 12");
   end
   if (BA_W < 2) begin : g_bad_baw
      $error("ddr2_init_seq: BA_W must be at least 2");
   end
   if (T_PWR < 1 || T_NOP < 1) begin : g_bad_wait
      $error("ddr2_init_seq: T_PWR and T_NOP must be at least 1");
   end
   if (T_RPA < 2 || T_MRD < 2 || T_RFC < 2) begin : g_bad_gap
      $error("ddr2_init_seq: command spacings must be at least 2");
   end

   ist_t           state;
   logic [3:0]     step;
   logic [A_W-1:0] mr_q, emr_q;
   logic           cfg_ok;
   logic [A_W-1:0] mr_w, emr_w;
   logic           t_load, t_zero;
   logic [CW-1:0]  t_val;
   logic           dll_arm, dll_locked;

   dcmd_t          step_cmd, cmd_now;
   logic [1:0]     step_ba;
   logic [A_W-1:0] step_addr;
   logic [CW-1:0]  step_gap;

   ddr2_init_cfg #(.A_W(A_W), .T_WR(T_WR)) i_cfg (
      .cas_lat(cas_lat), .add_lat(add_lat), .burst_len(burst_len),
      .drive_reduced(drive_reduced), .cfg_ok(cfg_ok),
      .mr_word(mr_w), .emr_word(emr_w)
   );

   ddr2_init_timer #(.CW(CW)) i_timer (
      .clk(clk), .rst(rst), .load(t_load), .val(t_val), .zero(t_zero)
   );

   ddr2_init_dll_gate #(.T_DLL(T_DLL)) i_dll (
      .clk(clk), .rst(rst), .arm(dll_arm), .locked(dll_locked)
   );

   // step table: command, bank, address word, issue-to-issue spacing
   always_comb begin
      step_cmd  = CMD_LMR;
      step_ba   = 2'd0;
      step_addr = '0;
      step_gap  = CW'(T_MRD);
      case (step)
         4'd0, 4'd5: begin
            step_cmd      = CMD_PRE;
            step_addr[10] = 1'b1;
            step_gap      = CW'(T_RPA);
         end
         4'd1: step_ba = 2'd2;
         4'd2: step_ba = 2'd3;
         4'd3: begin
            step_ba   = 2'd1;
            step_addr = emr_q;
         end
         4'd4: begin
            step_addr    = mr_q;
            step_addr[8] = 1'b1;
         end
         4'd6, 4'd7: begin
            step_cmd = CMD_REF;
            step_gap = CW'(T_RFC);
         end
         4'd8: step_addr = mr_q;
         4'd9: begin
            step_ba        = 2'd1;
            step_addr      = emr_q;
            step_addr[9:7] = 3'b111;
         end
         default: begin
            step_ba   = 2'd1;
            step_addr = emr_q;
         end
      endcase
   end

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      case (state)
         ST_IDLE: if (start && cfg_ok) begin
            t_load = 1'b1;
            t_val  = CW'(T_PWR - 1);
         end
         ST_PWR: if (t_zero) begin
            t_load = 1'b1;
            t_val  = CW'(T_NOP - 1);
         end
         ST_CMD: begin
            t_load = 1'b1;
            t_val  = step_gap - CW'(2);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         step    <= '0;
         cfg_err <= 1'b0;
         mr_q    <= '0;
         emr_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               cfg_err <= !cfg_ok;
               if (cfg_ok) begin
                  mr_q  <= mr_w;
                  emr_q <= emr_w;
                  state <= ST_PWR;
               end
            end
            ST_PWR:  if (t_zero) state <= ST_NOPW;
            ST_NOPW: if (t_zero) begin
               step  <= '0;
               state <= ST_CMD;
            end
            ST_CMD:  state <= ST_GAP;
            ST_GAP:  if (t_zero) begin
               if (step == LAST) state <= ST_DONE;
               else begin
                  step  <= step + 1'b1;
                  state <= ST_CMD;
               end
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   assign dll_arm = (state == ST_CMD) && (step == 4'(STEP_DLLRST));
   assign cmd_now = (state == ST_CMD) ? step_cmd : CMD_NOP;
   assign {cs_n, ras_n, cas_n, we_n} = cmd_now;
   assign cke        = (state != ST_IDLE) && (state != ST_PWR);
   assign addr       = (state == ST_CMD) ? step_addr : '0;
   assign init_done  = (state == ST_DONE);
   assign rd_allowed = init_done && dll_locked;

   if (BA_W > 2) begin : g_ba_wide
      assign ba = {{(BA_W-2){1'b0}}, (state == ST_CMD) ? step_ba : 2'd0};
   end else begin : g_ba_narrow
      assign ba = (state == ST_CMD) ? step_ba : 2'd0;
   end

   // R1: no command reaches the memory while clock-enable is low
   a_r1_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
      (cmd_now != CMD_NOP) |-> cke);

   // R2: clock-enable never drops again without a reset
   a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
      cke |=> cke);

   // R4: every command is followed by at least one NOP
   a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
      (cmd_now != CMD_NOP) |=> (cmd_now == CMD_NOP));

   // R7: completion is sticky
   a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R9: an error leaves the memory untouched
   a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> !cke);

endmodule

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;
   localparam int A_W   = 14;
   localparam int BA_W  = 3;
   localparam int T_PWR = 30;
   localparam int T_NOP = 8;
   localparam int T_RPA = 2;
   localparam int T_MRD = 3;
   localparam int T_RFC = 7;
   localparam int T_DLL = 200;
   localparam int T_WR  = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [2:0] cas_lat = 3'd5;
   logic [2:0] add_lat = 3'd0;
   logic [3:0] burst_len = 4'd8;
   logic drive_reduced = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, init_done, rd_allowed, cfg_err;
   logic [BA_W-1:0] ba;
   logic [A_W-1:0] addr;

   ddr2_init_seq #(
      .A_W(A_W), .BA_W(BA_W), .T_PWR(T_PWR), .T_NOP(T_NOP), .T_RPA(T_RPA),
      .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLL(T_DLL), .T_WR(T_WR)
   ) i_ddr2_init_seq (
      .clk(clk), .rst(rst), .start(start), .cas_lat(cas_lat), .add_lat(add_lat),
      .burst_len(burst_len), .drive_reduced(drive_reduced), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
      .addr(addr), .init_done(init_done), .rd_allowed(rd_allowed), .cfg_err(cfg_err)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int              at;
      logic [3:0]      cmd;
      logic [BA_W-1:0] bank;
      logic [A_W-1:0]  word;
      string           tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string act, input string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %s expected %s", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: every non-NOP command must match the head of the queue
   always @(negedge clk) begin
      if (!rst && {cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
         if (q.size() == 0) begin
            chk(1'b0, "R3 unexpected command",
                $sformatf("cmd=%b ba=%0d a=%h @%0d", {cs_n, ras_n, cas_n, we_n}, ba, addr, cyc),
                "no command");
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.cmd == {cs_n, ras_n, cas_n, we_n} && e.bank == ba && e.word == addr && e.at == cyc,
                e.tag,
                $sformatf("cmd=%b ba=%0d a=%h @%0d", {cs_n, ras_n, cas_n, we_n}, ba, addr, cyc),
                $sformatf("cmd=%b ba=%0d a=%h @%0d", e.cmd, e.bank, e.word, e.at));
         end
      end
   end

   function automatic logic [A_W-1:0] mr_val(input int cl, input int bl, input bit dllrst);
      logic [A_W-1:0] a = '0;
      a[2:0]  = (bl == 8) ? 3'b011 : 3'b010;
      a[6:4]  = 3'(cl);
      a[8]    = dllrst;
      a[11:9] = 3'(T_WR - 1);
      return a;
   endfunction

   function automatic logic [A_W-1:0] emr_val(input int al, input bit drv, input bit ocd);
      logic [A_W-1:0] a = '0;
      a[1]   = drv;
      a[5:3] = 3'(al);
      a[9:7] = ocd ? 3'b111 : 3'b000;
      return a;
   endfunction

   // driver: start a legal run, push the eleven expected commands, check flags
   task automatic run_seq(input int cl, input int al, input int bl, input bit drv, input bit disturb);
      int t0, base, off, t_dll, t_done;
      logic [A_W-1:0] pre_a;
      pre_a = '0;
      pre_a[10] = 1'b1;
      @(negedge clk);
      cas_lat = 3'(cl); add_lat = 3'(al); burst_len = 4'(bl); drive_reduced = drv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t0 = cyc;
      chk(cfg_err == 1'b0, "R9 legal start clears error", $sformatf("%b", cfg_err), "0");
      base = t0 + T_PWR + T_NOP;
      off = 0;
      t_dll = 0;
      for (int i = 0; i < 11; i++) begin
         exp_t e;
         e.at = base + off;
         e.bank = '0;
         e.word = '0;
         case (i)
            0, 5: begin e.cmd = 4'b0010; e.word = pre_a; e.tag = "R3 R4 precharge"; off += T_RPA; end
            1:    begin e.cmd = 4'b0000; e.bank = 2; e.tag = "R5 ext2 load"; off += T_MRD; end
            2:    begin e.cmd = 4'b0000; e.bank = 3; e.tag = "R5 ext3 load"; off += T_MRD; end
            3:    begin e.cmd = 4'b0000; e.bank = 1; e.word = emr_val(al, drv, 0); e.tag = "R5 ext DLL on"; off += T_MRD; end
            4:    begin e.cmd = 4'b0000; e.word = mr_val(cl, bl, 1); e.tag = "R6 base DLL reset";
                        t_dll = e.at + T_DLL; off += T_MRD; end
            6, 7: begin e.cmd = 4'b0001; e.tag = "R3 R4 refresh"; off += T_RFC; end
            8:    begin e.cmd = 4'b0000; e.word = mr_val(cl, bl, 0); e.tag = "R6 base no reset"; off += T_MRD; end
            9:    begin e.cmd = 4'b0000; e.bank = 1; e.word = emr_val(al, drv, 1); e.tag = "R5 calib default"; off += T_MRD; end
            default: begin e.cmd = 4'b0000; e.bank = 1; e.word = emr_val(al, drv, 0); e.tag = "R5 calib exit"; off += T_MRD; end
         endcase
         q.push_back(e);
      end
      t_done = base + off;
      if (disturb) begin
         // R10: new settings and a second start while running
         @(negedge clk);
         cas_lat = 3'd7; add_lat = 3'd1; burst_len = 4'd4; drive_reduced = ~drv;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_cyc(t0 + T_PWR - 1);
      chk(cke == 1'b0, "R2 cke low in settle", $sformatf("%b", cke), "0");
      wait_cyc(t0 + T_PWR);
      chk(cke == 1'b1, "R2 cke rises", $sformatf("%b", cke), "1");
      wait_cyc(t_done - 1);
      chk(init_done == 1'b0, "R7 done not early", $sformatf("%b", init_done), "0");
      chk(rd_allowed == 1'b0, "R8 read gate before done", $sformatf("%b", rd_allowed), "0");
      wait_cyc(t_done);
      chk(init_done == 1'b1, "R7 done on time", $sformatf("%b", init_done), "1");
      chk(q.size() == 0, "R3 all commands seen", $sformatf("%0d left", q.size()), "0 left");
      if (t_dll > t_done) begin
         wait_cyc(t_dll - 1);
         chk(rd_allowed == 1'b0, "R8 read gate before lock", $sformatf("%b", rd_allowed), "0");
         wait_cyc(t_dll);
      end
      chk(rd_allowed == 1'b1, "R8 read gate at lock", $sformatf("%b", rd_allowed), "1");
      repeat (10) @(negedge clk);
      chk(init_done && rd_allowed, "R7 flags stay high", $sformatf("%b%b", init_done, rd_allowed), "11");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk({cke, init_done, rd_allowed, cfg_err} == 4'b0000, "R11 reset clears",
          $sformatf("%b", {cke, init_done, rd_allowed, cfg_err}), "0000");
   endtask

   task automatic bad_cfg(input int cl, input int al, input int bl);
      @(negedge clk);
      cas_lat = 3'(cl); add_lat = 3'(al); burst_len = 4'(bl);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cfg_err == 1'b1, "R9 error flagged", $sformatf("%b", cfg_err), "1");
      repeat (40) @(negedge clk);
      chk(cke == 1'b0 && init_done == 1'b0, "R9 sequence not run",
          $sformatf("cke=%b done=%b", cke, init_done), "cke=0 done=0");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk({cke, cs_n, ras_n, cas_n, we_n} == 5'b00111, "R1 idle pins",
          $sformatf("%b", {cke, cs_n, ras_n, cas_n, we_n}), "00111");
      chk({init_done, rd_allowed, cfg_err} == 3'b000, "R1 idle flags",
          $sformatf("%b", {init_done, rd_allowed, cfg_err}), "000");
      repeat (20) @(negedge clk);
      chk(cke == 1'b0, "R1 waits for start", $sformatf("%b", cke), "0");

      run_seq(5, 2, 8, 1'b0, 1'b1);
      do_reset();

      bad_cfg(2, 0, 8);
      bad_cfg(5, 6, 4);
      bad_cfg(5, 0, 6);
      run_seq(3, 0, 4, 1'b1, 1'b0);

      do_reset();
      run_seq(7, 5, 8, 1'b0, 1'b0);

      // R11: reset during the NOP phase before the first command
      do_reset();
      begin
         int t0;
         @(negedge clk);
         cas_lat = 3'd4; add_lat = 3'd1; burst_len = 4'd4; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         t0 = cyc;
         wait_cyc(t0 + T_PWR + 2);
         chk(cke == 1'b1, "R2 cke high in NOP phase", $sformatf("%b", cke), "1");
         do_reset();
         repeat (60) @(negedge clk);
         chk(cke == 1'b0, "R11 stays idle after reset", $sformatf("%b", cke), "0");
      end
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule